// File: doc/BRIEF.md
# Fuzzy Hardware Barrier Unit

This unit synchronizes a set of processors (eight by default) without any polling of shared memory. A processor announces that it has entered its barrier region with a one-cycle arrive pulse. The pulse carries two things: a participant mask that names the processors taking part, and a small barrier tag. After that pulse the processor keeps executing the independent instructions of its region. At the end of the region it raises an exit request. The unit stalls the processor only while the exit request is high and some participant of its barrier has not yet arrived with the same mask and tag. If all of them are already in, the processor passes without losing a cycle.

Each processor holds at most one pending arrival. A barrier is released in the cycle in which its last member arrives. All members are cleared together, so any of them may arrive at its next barrier on the following cycle. Processor subsets with disjoint masks synchronize independently and at the same time. Tags keep consecutive or unrelated barriers apart. Inconsistent use raises a sticky error flag, which only reset clears. Inconsistent use means a conflicting mask or tag, or a second arrival while one is still pending.

Top module: `fuzzy_barrier`

## Requirements
- R1: After synchronous active-high reset, `arrived_o` is all zero and `err_o` is low. With no arrival pending, `stall_o` stays low for every processor even if all exit requests are high.
- R2: An accepted arrival that does not complete its barrier sets `arrived_o[p]` at the next clock edge. No processor's `arrived_o` bit rises without an arrive pulse on its own input. While its exit request is low, a pending processor is never stalled.
- R3: `stall_o[p]` is combinational. It is high exactly while `exit_req_i[p]` is high, processor p is pending or arriving in that cycle, and its barrier is not complete in that cycle. An exit request from a processor with nothing pending is never stalled.
- R4: A barrier completes in the cycle in which every processor whose bit is set in its mask is pending or arriving. All of them must hold the identical mask and tag. The arriving processor's own bit is always treated as set, and bit j of the mask names processor j. In that cycle the stall of every member drops, and at the next edge every member's `arrived_o` clears.
- R5: Processors outside a barrier's mask are not required for its release and are left untouched by it.
- R6: Barriers with disjoint masks proceed and release independently, in the same cycle or in different cycles, without raising `err_o`.
- R7: Arrivals whose tags differ never count toward the same barrier instance, even when their masks are equal.
- R8: An accepted arrival sets `err_o` at the next edge in one case. Some other processor inside its mask must be pending or arriving in the same cycle, with a different mask or a different tag.
- R9: An arrive pulse from a processor that is already pending is ignored, and the stored mask and tag are kept. It sets `err_o` at the next edge.
- R10: An arrival whose mask names only the arriving processor completes in its own cycle. It is not stalled even with its exit request high in that cycle, and `arrived_o` stays low.
- R11: A processor released at an edge may arrive at a new barrier in the very next cycle, and that arrival is accepted.
- R12: Once set, `err_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arrive_i | input | NPROC | One-cycle arrive pulse per processor |
| arrive_mask_i | input | NPROC*NPROC | Participant mask per processor; processor p uses bits [p*NPROC +: NPROC] |
| arrive_tag_i | input | NPROC*TAG_W | Barrier tag per processor; processor p uses bits [p*TAG_W +: TAG_W] |
| exit_req_i | input | NPROC | Level: the processor has reached the end of its barrier region |
| stall_o | output | NPROC | Combinational stall per processor |
| arrived_o | output | NPROC | Registered pending-arrival state per processor |
| err_o | output | 1 | Sticky error flag for conflicting or repeated arrivals |

## Verification
The stall result is due in the same cycle as the inputs that cause it. The bench drives new inputs just after a falling edge and compares `stall_o` one nanosecond later, before the next rising edge. The pending state and the error flag each pass through one register. They are therefore compared at the falling edge that follows the capturing rising edge, against a bench model that is advanced at that same rising edge. Directed cases and random cases both go through this same step, so every comparison lands in the cycle where the result is due.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    localparam int unsigned NPROC_DEFAULT = 8;
    localparam int unsigned TAG_W_DEFAULT = 4;

    // Disposition of an arrive pulse for one processor in one cycle
    typedef enum logic [1:0] {
        ARV_IDLE   = 2'd0,
        ARV_TAKE   = 2'd1,
        ARV_REFUSE = 2'd2
    } arv_kind_e;

endpackage

// File: rtl/fbu_arrive_gate.sv
module fbu_arrive_gate #(
    parameter int unsigned NPROC = 8,
    parameter int unsigned TAG_W = 4,
    parameter int unsigned SELF  = 0
) (
    input  logic                  arrive_i,
    input  logic [NPROC-1:0]      mask_i,
    input  logic [TAG_W-1:0]      tag_i,
    input  logic                  busy_q_i,
    input  logic [NPROC-1:0]      mask_q_i,
    input  logic [TAG_W-1:0]      tag_q_i,
    output fbu_pkg::arv_kind_e    kind_o,
    output logic                  busy_o,
    output logic [NPROC-1:0]      mask_o,
    output logic [TAG_W-1:0]      tag_o
);
    localparam logic [NPROC-1:0] ONE      = 1;
    localparam logic [NPROC-1:0] SELF_BIT = ONE << SELF;

    always_comb begin
        kind_o = fbu_pkg::ARV_IDLE;
        if (arrive_i) begin
            kind_o = busy_q_i ? fbu_pkg::ARV_REFUSE : fbu_pkg::ARV_TAKE;
        end
        if (kind_o == fbu_pkg::ARV_TAKE) begin
            busy_o = 1'b1;
            mask_o = mask_i | SELF_BIT;   // a processor always belongs to its own barrier
            tag_o  = tag_i;
        end else begin
            busy_o = busy_q_i;
            mask_o = mask_q_i;
            tag_o  = tag_q_i;
        end
    end
endmodule

// File: rtl/fbu_group_eval.sv
module fbu_group_eval #(
    parameter int unsigned NPROC = 8,
    parameter int unsigned TAG_W = 4,
    parameter int unsigned SELF  = 0
) (
    input  logic [NPROC-1:0]       busy_i,
    input  logic [NPROC*NPROC-1:0] masks_i,
    input  logic [NPROC*TAG_W-1:0] tags_i,
    input  logic                   take_i,
    output logic                   done_o,
    output logic                   clash_o
);
    logic [NPROC-1:0] own_mask;
    logic [TAG_W-1:0] own_tag;
    logic [NPROC-1:0] peer_mask;
    logic [TAG_W-1:0] peer_tag;
    logic             peer_same;
    logic             all_in;
    logic             clash;

    always_comb begin
        own_mask  = masks_i[SELF*NPROC +: NPROC];
        own_tag   = tags_i[SELF*TAG_W +: TAG_W];
        peer_mask = '0;
        peer_tag  = '0;
        peer_same = 1'b0;
        all_in    = 1'b1;
        clash     = 1'b0;
        for (int j = 0; j < int'(NPROC); j++) begin
            peer_mask = masks_i[j*NPROC +: NPROC];
            peer_tag  = tags_i[j*TAG_W +: TAG_W];
            peer_same = (peer_mask == own_mask) && (peer_tag == own_tag);
            if (own_mask[j]) begin
                if (!busy_i[j] || !peer_same) begin
                    all_in = 1'b0;
                end
                if ((j != int'(SELF)) && busy_i[j] && !peer_same) begin
                    clash = 1'b1;
                end
            end
        end
        done_o  = busy_i[SELF] && all_in;
        clash_o = take_i && clash;
    end
endmodule

// File: rtl/fuzzy_barrier.sv
module fuzzy_barrier #(
    parameter int unsigned NPROC = fbu_pkg::NPROC_DEFAULT,
    parameter int unsigned TAG_W = fbu_pkg::TAG_W_DEFAULT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPROC-1:0]       arrive_i,
    input  logic [NPROC*NPROC-1:0] arrive_mask_i,
    input  logic [NPROC*TAG_W-1:0] arrive_tag_i,
    input  logic [NPROC-1:0]       exit_req_i,
    output logic [NPROC-1:0]       stall_o,
    output logic [NPROC-1:0]       arrived_o,
    output logic                   err_o
);
    typedef struct packed {
        logic [NPROC-1:0]       busy;
        logic [NPROC*NPROC-1:0] masks;
        logic [NPROC*TAG_W-1:0] tags;
        logic                   err;
    } bar_state_t;

    bar_state_t state_q, state_d;

    // Effective view of this cycle: stored state merged with accepted arrivals
    logic [NPROC-1:0]       eff_busy;
    logic [NPROC*NPROC-1:0] eff_masks;
    logic [NPROC*TAG_W-1:0] eff_tags;
    logic [NPROC-1:0]       take;
    logic [NPROC-1:0]       refuse;
    logic [NPROC-1:0]       done;
    logic [NPROC-1:0]       clash;
    fbu_pkg::arv_kind_e     kind [NPROC];

    for (genvar g = 0; g < NPROC; g++) begin : g_proc
        fbu_arrive_gate #(
            .NPROC (NPROC),
            .TAG_W (TAG_W),
            .SELF  (g)
        ) u_gate (
            .arrive_i (arrive_i[g]),
            .mask_i   (arrive_mask_i[g*NPROC +: NPROC]),
            .tag_i    (arrive_tag_i[g*TAG_W +: TAG_W]),
            .busy_q_i (state_q.busy[g]),
            .mask_q_i (state_q.masks[g*NPROC +: NPROC]),
            .tag_q_i  (state_q.tags[g*TAG_W +: TAG_W]),
            .kind_o   (kind[g]),
            .busy_o   (eff_busy[g]),
            .mask_o   (eff_masks[g*NPROC +: NPROC]),
            .tag_o    (eff_tags[g*TAG_W +: TAG_W])
        );

        assign take[g]   = (kind[g] == fbu_pkg::ARV_TAKE);
        assign refuse[g] = (kind[g] == fbu_pkg::ARV_REFUSE);

        fbu_group_eval #(
            .NPROC (NPROC),
            .TAG_W (TAG_W),
            .SELF  (g)
        ) u_eval (
            .busy_i  (eff_busy),
            .masks_i (eff_masks),
            .tags_i  (eff_tags),
            .take_i  (take[g]),
            .done_o  (done[g]),
            .clash_o (clash[g])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.busy  = eff_busy & ~done;
        state_d.masks = eff_masks;
        state_d.tags  = eff_tags;
        state_d.err   = state_q.err | (|refuse) | (|clash);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stall_o   = exit_req_i & eff_busy & ~done;
    assign arrived_o = state_q.busy;
    assign err_o     = state_q.err;

endmodule

// File: rtl/fbu_checker.sv
module fbu_checker #(
    parameter int unsigned NPROC = 8,
    parameter int unsigned TAG_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NPROC-1:0]       arrive_i,
    input logic [NPROC*NPROC-1:0] arrive_mask_i,
    input logic [NPROC-1:0]       exit_req_i,
    input logic [NPROC-1:0]       stall_o,
    input logic [NPROC-1:0]       arrived_o,
    input logic                   err_o
);
    localparam logic [NPROC-1:0] ONE = 1;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (arrived_o == '0) && !err_o);

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    for (genvar i = 0; i < NPROC; i++) begin : g_chk
        assert_no_spurious_arrival_R2: assert property (@(posedge clk) disable iff (rst)
            !arrived_o[i] && !arrive_i[i] |=> !arrived_o[i]);

        assert_stall_needs_exit_R3: assert property (@(posedge clk) disable iff (rst)
            stall_o[i] |-> exit_req_i[i] && (arrived_o[i] || arrive_i[i]));

        assert_stalled_stays_pending_R4: assert property (@(posedge clk) disable iff (rst)
            stall_o[i] |=> arrived_o[i]);

        assert_repeat_arrival_flags_R9: assert property (@(posedge clk) disable iff (rst)
            arrive_i[i] && arrived_o[i] |=> err_o);

        assert_self_barrier_no_stall_R10: assert property (@(posedge clk) disable iff (rst)
            arrive_i[i] && !arrived_o[i] && (arrive_mask_i[i*NPROC +: NPROC] == (ONE << i))
            |-> !stall_o[i]);

        assert_self_barrier_clears_R10: assert property (@(posedge clk) disable iff (rst)
            arrive_i[i] && !arrived_o[i] && (arrive_mask_i[i*NPROC +: NPROC] == (ONE << i))
            |=> !arrived_o[i]);
    end
endmodule

bind fuzzy_barrier fbu_checker #(
    .NPROC (NPROC),
    .TAG_W (TAG_W)
) u_fbu_checker (
    .clk           (clk),
    .rst           (rst),
    .arrive_i      (arrive_i),
    .arrive_mask_i (arrive_mask_i),
    .exit_req_i    (exit_req_i),
    .stall_o       (stall_o),
    .arrived_o     (arrived_o),
    .err_o         (err_o)
);

// File: tb/tb_fuzzy_barrier.sv
module tb_fuzzy_barrier;
    localparam int N  = 8;
    localparam int TW = 4;
    localparam logic [N-1:0] ONE = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [N-1:0]    arr = '0;
    logic [N-1:0]    exq = '0;
    logic [N-1:0]    amask [N];
    logic [TW-1:0]   atag  [N];
    logic [N*N-1:0]  amask_flat;
    logic [N*TW-1:0] atag_flat;
    logic [N-1:0]    stall_o;
    logic [N-1:0]    arrived_o;
    logic            err_o;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            amask_flat[i*N +: N]   = amask[i];
            atag_flat[i*TW +: TW]  = atag[i];
        end
    end

    fuzzy_barrier #(.NPROC(N), .TAG_W(TW)) dut (
        .clk           (clk),
        .rst           (rst),
        .arrive_i      (arr),
        .arrive_mask_i (amask_flat),
        .arrive_tag_i  (atag_flat),
        .exit_req_i    (exq),
        .stall_o       (stall_o),
        .arrived_o     (arrived_o),
        .err_o         (err_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model of the requirements
    logic [N-1:0]  m_busy;
    logic [N-1:0]  m_mask [N];
    logic [TW-1:0] m_tag  [N];
    logic          m_err;
    logic [N-1:0]  x_busy, x_done, x_stall;
    logic [N-1:0]  x_mask [N];
    logic [TW-1:0] x_tag  [N];
    logic          x_err;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_busy = '0;
        m_err  = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_mask[i] = '0;
            m_tag[i]  = '0;
        end
    endtask

    task automatic model_eval();
        x_err = m_err;
        for (int i = 0; i < N; i++) begin
            if (arr[i] && !m_busy[i]) begin
                x_busy[i] = 1'b1;
                x_mask[i] = amask[i] | (ONE << i);
                x_tag[i]  = atag[i];
            end else begin
                x_busy[i] = m_busy[i];
                x_mask[i] = m_mask[i];
                x_tag[i]  = m_tag[i];
                if (arr[i]) x_err = 1'b1;            // R9
            end
        end
        for (int i = 0; i < N; i++) begin
            logic ok;
            ok = x_busy[i];
            for (int j = 0; j < N; j++) begin
                if (x_mask[i][j]) begin
                    logic same;
                    same = (x_mask[j] == x_mask[i]) && (x_tag[j] == x_tag[i]);
                    if (!(x_busy[j] && same)) ok = 1'b0;
                    if (j != i && x_busy[j] && !same && arr[i] && !m_busy[i]) x_err = 1'b1; // R8
                end
            end
            x_done[i] = ok;
        end
        x_stall = exq & x_busy & ~x_done;
    endtask

    task automatic model_commit();
        m_busy = x_busy & ~x_done;
        for (int i = 0; i < N; i++) begin
            m_mask[i] = x_mask[i];
            m_tag[i]  = x_tag[i];
        end
        m_err = x_err;
    endtask

    task automatic clear_inputs();
        arr = '0;
        for (int i = 0; i < N; i++) begin
            amask[i] = '0;
            atag[i]  = '0;
        end
    endtask

    task automatic set_arr(int p, logic [N-1:0] m, logic [TW-1:0] t);
        arr[p]   = 1'b1;
        amask[p] = m;
        atag[p]  = t;
    endtask

    // Called just after a falling edge with the inputs of this cycle applied
    task automatic step(string req);
        #1;
        model_eval();
        chk(req, "stall_o", 32'(stall_o), 32'(x_stall));
        @(posedge clk);
        model_commit();
        @(negedge clk);
        chk(req, "arrived_o", 32'(arrived_o), 32'(m_busy));
        chk(req, "err_o", 32'(err_o), 32'(m_err));
        clear_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clear_inputs();
        exq = '0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        exq = '1;
        #1;
        chk("R1", "stall_o", 32'(stall_o), 32'h0);
        chk("R1", "arrived_o", 32'(arrived_o), 32'h0);
        chk("R1", "err_o", 32'(err_o), 32'h0);
        exq = '0;
    endtask

    function automatic logic [N-1:0] grp_mask(int p);
        if (p < 4)  return 8'h0F;
        if (p < 6)  return 8'h30;
        if (p == 6) return 8'h40;
        return 8'h80;
    endfunction

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0b01));
        clear_inputs();
        model_reset();

        // R1 reset
        do_reset();

        // R10 single-processor barrier with exit in the same cycle
        set_arr(3, 8'h08, 4'd5);
        exq[3] = 1'b1;
        #1;
        chk("R10", "stall_o[3] same cycle", 32'(stall_o[3]), 32'h0);
        step("R10");
        chk("R10", "arrived_o[3]", 32'(arrived_o[3]), 32'h0);
        exq = '0;

        // R2 R3 R4 full barrier, processor 0 stalls at its exit
        exq[5] = 1'b1;   // R3: exit with nothing pending
        #1;
        chk("R3", "idle exit stall", 32'(stall_o[5]), 32'h0);
        exq[5] = 1'b0;
        for (int p = 0; p < 7; p++) begin
            set_arr(p, 8'hFF, 4'd2);
            step("R2");
            exq[0] = 1'b1;
        end
        chk("R2", "seven pending", 32'(arrived_o), 32'h7F);
        #1;
        chk("R3", "stall_o[0] waiting", 32'(stall_o[0]), 32'h1);
        set_arr(7, 8'hFF, 4'd2);
        #1;
        chk("R4", "stall_o[0] drops on last arrive", 32'(stall_o[0]), 32'h0);
        step("R4");
        chk("R4", "all released", 32'(arrived_o), 32'h0);
        exq = '0;

        // R5 R6 two disjoint groups
        set_arr(0, 8'h03, 4'd1);
        set_arr(2, 8'h0C, 4'd1);
        step("R6");
        exq = 8'h0F;
        set_arr(1, 8'h03, 4'd1);
        step("R5");
        chk("R6", "group B still pending", 32'(arrived_o), 32'h04);
        // R11 immediate re-arrival of a released member
        set_arr(0, 8'h01, 4'd7);
        set_arr(3, 8'h0C, 4'd1);
        step("R11");
        chk("R11", "re-arrival completed", 32'(arrived_o), 32'h00);
        chk("R6", "no error", 32'(err_o), 32'h0);
        set_arr(1, 8'h03, 4'd4);
        step("R11");
        chk("R11", "re-arrival accepted", 32'(arrived_o), 32'h02);
        exq = '0;

        // R7 R8 tag mismatch with equal masks
        do_reset();
        set_arr(4, 8'h30, 4'd1);
        set_arr(5, 8'h30, 4'd2);
        step("R7");
        chk("R7", "no release", 32'(arrived_o), 32'h30);
        chk("R8", "tag clash flagged", 32'(err_o), 32'h1);
        for (int k = 0; k < 4; k++) step("R12");
        chk("R12", "err sticky", 32'(err_o), 32'h1);

        // R9 repeated arrive is ignored
        do_reset();
        set_arr(6, 8'hC0, 4'd3);
        step("R9");
        set_arr(6, 8'h40, 4'd9);
        step("R9");
        chk("R9", "err set", 32'(err_o), 32'h1);
        chk("R9", "still pending", 32'(arrived_o), 32'h40);
        set_arr(7, 8'hC0, 4'd3);
        step("R9");
        chk("R9", "original mask/tag kept", 32'(arrived_o), 32'h00);

        // R8 mask mismatch
        do_reset();
        set_arr(0, 8'h03, 4'd1);
        step("R8");
        set_arr(1, 8'h07, 4'd1);
        step("R8");
        chk("R8", "mask clash flagged", 32'(err_o), 32'h1);

        // Random traffic on consistent groups
        do_reset();
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < N; p++) begin
                if (!m_busy[p] && ($urandom % 4 == 0)) set_arr(p, grp_mask(p), 4'(p / 4));
            end
            exq = N'($urandom);
            step("R6");
        end
        chk("R6", "random groups error-free", 32'(err_o), 32'h0);

        // Random traffic with arbitrary masks and tags
        for (int c = 0; c < 2000; c++) begin
            if (c % 50 == 0) do_reset();
            for (int p = 0; p < N; p++) begin
                if ($urandom % 5 == 0)
                    set_arr(p, N'($urandom) & N'($urandom), 4'($urandom % 2));
            end
            exq = N'($urandom);
            step("R8");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule